// File: doc/BRIEF.md
# Receive Character Buffer with Line Status

This block sits behind the character assembler of a 16550-style serial port. Each completed character arrives on a one-cycle strobe with its data byte and goes into a 16-entry first-in first-out store. The host takes characters out through a pop request, and the byte appears on a registered data output one cycle later. Storage is a simple dual-port array with a registered read port, so an FPGA can place it in block RAM.

Three flags are kept beside the store. The data-ready flag shows that at least one unread character is waiting. The overrun flag is sticky and is cleared by reading line status. When a character arrives while the store is full and nothing is popped in that cycle, the stored contents stay as they are and the new byte is dropped. The interrupt flag is raised while the fill level is at or above a threshold that the host selects.

A control write port holds an enable bit that resets to 1, a two-bit threshold select, and two self-clearing bits. One of these empties the receive store. The other produces a one-cycle pulse for the transmit-side pointers, which lie outside this block. The threshold select and both clear bits are accepted only from a write that also carries the enable bit.

Top module: `rx_char_buffer`

## Requirements
- R1: After synchronous reset the fill level is 0, data_ready, overrun and trig_irq are 0, fifo_on is 1, and the threshold is one character.
- R2: Characters are returned in arrival order. rx_data holds the popped byte from the cycle after pop_req. A pop while empty changes neither rx_data nor rx_level.
- R3: A character strobe while rx_level is 16 and no pop is accepted sets overrun on the next cycle, leaves rx_level at 16 and the stored bytes unchanged, and drops the new byte.
- R4: A strobe and a pop in the same cycle while full is not an overrun. rx_level stays 16 and the new byte is stored behind the others.
- R5: A pulse on lsr_rd clears overrun. If an overrun happens in the same cycle as lsr_rd, overrun stays 1.
- R6: data_ready is 1 exactly when rx_level is nonzero.
- R7: ctrl_wdata[5:4] selects the threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 characters. trig_irq is 1 while rx_level is at or above the threshold and drops as soon as the level falls below it.
- R8: A control write with ctrl_wdata[1]=1 (and enable bit set) empties the store one cycle after the write. rx_level and data_ready go to 0 and overrun keeps its value.
- R9: A control write with ctrl_wdata[2]=1 (and enable bit set) drives tx_ptr_clr high for exactly one cycle and leaves the receive store untouched.
- R10: ctrl_wdata[0] is the enable bit and is shown on fifo_on. A write with bit 0 clear leaves the threshold unchanged and ignores both clear bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_valid | input | 1 | One-cycle strobe for a completed character |
| char_data | input | 8 | Byte of the completed character |
| pop_req | input | 1 | Host removes the oldest character |
| rx_data | output | 8 | Registered byte of the last accepted pop |
| lsr_rd | input | 1 | Line-status read, clears overrun |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control word: bit0 enable, bit1 receive clear, bit2 transmit clear, bits 5:4 threshold |
| data_ready | output | 1 | At least one unread character |
| overrun | output | 1 | Sticky overrun status |
| trig_irq | output | 1 | Fill level at or above the threshold |
| rx_level | output | 5 | Number of stored characters |
| tx_ptr_clr | output | 1 | One-cycle transmit pointer clear pulse |
| fifo_on | output | 1 | Current enable bit |

## Verification
The assertions check on every cycle that the fill level never goes above the depth, that a full store with a push and no pop stays full and raises overrun, that a simultaneous push and pop at full keeps the level, that data_ready follows the level, that the clear bits last one cycle, and that the overrun set and clear priority holds. Only the bench scenarios can show that the bytes come back in order with the dropped byte missing, that each threshold code gives the right interrupt edge, and that a disabled write leaves the threshold alone.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  typedef enum logic [1:0] {
    TRIG_1  = 2'b00,
    TRIG_4  = 2'b01,
    TRIG_8  = 2'b10,
    TRIG_14 = 2'b11
  } trig_sel_e;

  localparam int CW_EN     = 0;
  localparam int CW_RXCLR  = 1;
  localparam int CW_TXCLR  = 2;
  localparam int CW_TRIGLO = 4;

  function automatic int unsigned trig_threshold(trig_sel_e s);
    case (s)
      TRIG_1:  return 1;
      TRIG_4:  return 4;
      TRIG_8:  return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/rxb_ctrl.sv
module rxb_ctrl
  import rxb_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  output logic          fifo_on,
  output trig_sel_e     trig_sel,
  output logic          rx_clr,
  output logic          tx_clr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_on  <= 1'b1;
      trig_sel <= TRIG_1;
      rx_clr   <= 1'b0;
      tx_clr   <= 1'b0;
    end else if (wr) begin
      fifo_on <= wdata[CW_EN];
      if (wdata[CW_EN]) begin
        trig_sel <= trig_sel_e'(wdata[CW_TRIGLO +: 2]);
        rx_clr   <= wdata[CW_RXCLR];
        tx_clr   <= wdata[CW_TXCLR];
      end else begin
        rx_clr <= 1'b0;
        tx_clr <= 1'b0;
      end
    end else begin
      rx_clr <= 1'b0;
      tx_clr <= 1'b0;
    end
  end

  assert_rxclr_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    (rx_clr && !wr) |=> !rx_clr);
  assert_txclr_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    (tx_clr && !wr) |=> !tx_clr);
  assert_trig_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (wr && !wdata[CW_EN]) |=> ($stable(trig_sel) && !rx_clr && !tx_clr));
endmodule

// File: rtl/rxb_fifo.sv
module rxb_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  count_next,
  output logic              ovf_evt
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic              full, empty, push_ok, pop_ok;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign pop_ok  = pop && !empty && !clr;
  assign push_ok = push && !clr && (!full || pop_ok);
  assign ovf_evt = push && !clr && full && !pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    if (clr) count_next = '0;
    else     count_next = count + CNT_W'(push_ok) - CNT_W'(pop_ok);
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (pop_ok) rdata <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= bump(wptr);
      if (pop_ok)  rptr <= bump(rptr);
      count <= count_next;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  assert_full_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clr) |=> (count == CNT_W'(DEPTH) && $stable(wptr)));
  assert_full_swap_R4: assert property (@(posedge clk) disable iff (rst)
    (full && push && pop && !clr) |=> count == CNT_W'(DEPTH));
  assert_empty_pop_R2: assert property (@(posedge clk) disable iff (rst)
    (empty && pop) |=> $stable(rdata));
  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> count == '0);
endmodule

// File: rtl/rxb_status.sv
module rxb_status
  import rxb_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ovf_evt,
  input  logic             lsr_rd,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] count_next,
  input  trig_sel_e        trig_sel,
  output logic             overrun,
  output logic             data_ready,
  output logic             trig_irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      overrun    <= 1'b0;
      data_ready <= 1'b0;
      trig_irq   <= 1'b0;
    end else begin
      if (ovf_evt)     overrun <= 1'b1;
      else if (lsr_rd) overrun <= 1'b0;
      data_ready <= (count_next != '0);
      trig_irq   <= (32'(count_next) >= trig_threshold(trig_sel));
    end
  end

  assert_ovr_set_R3: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> overrun);
  assert_ovr_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd && !ovf_evt) |=> !overrun);
  assert_ovr_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (overrun && !lsr_rd) |=> overrun);
  assert_ready_level_R6: assert property (@(posedge clk) disable iff (rst)
    data_ready == (count != '0));
endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer
  import rxb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int CW     = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              char_valid,
  input  logic [DATA_W-1:0] char_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] rx_data,
  input  logic              lsr_rd,
  input  logic              ctrl_wr,
  input  logic [CW-1:0]     ctrl_wdata,
  output logic              data_ready,
  output logic              overrun,
  output logic              trig_irq,
  output logic [CNT_W-1:0]  rx_level,
  output logic              tx_ptr_clr,
  output logic              fifo_on
);
  trig_sel_e        trig_sel;
  logic             rx_clr, ovf_evt;
  logic [CNT_W-1:0] count_next;

  rxb_ctrl #(.CW(CW)) ctrl_i (
    .clk(clk), .rst(rst), .wr(ctrl_wr), .wdata(ctrl_wdata),
    .fifo_on(fifo_on), .trig_sel(trig_sel), .rx_clr(rx_clr), .tx_clr(tx_ptr_clr)
  );

  rxb_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst(rst), .clr(rx_clr), .push(char_valid), .wdata(char_data),
    .pop(pop_req), .rdata(rx_data), .count(rx_level), .count_next(count_next),
    .ovf_evt(ovf_evt)
  );

  rxb_status #(.CNT_W(CNT_W)) status_i (
    .clk(clk), .rst(rst), .ovf_evt(ovf_evt), .lsr_rd(lsr_rd),
    .count(rx_level), .count_next(count_next), .trig_sel(trig_sel),
    .overrun(overrun), .data_ready(data_ready), .trig_irq(trig_irq)
  );
endmodule

// File: tb/rx_char_buffer_tb_top.sv
module rx_char_buffer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       char_valid = 1'b0, pop_req = 1'b0, lsr_rd = 1'b0, ctrl_wr = 1'b0;
  logic [7:0] char_data = '0, ctrl_wdata = '0, rx_data;
  logic       data_ready, overrun, trig_irq, tx_ptr_clr, fifo_on;
  logic [4:0] rx_level;
  int         n_run = 0, n_fail = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  rx_char_buffer dut_i (
    .clk(clk), .rst(rst), .char_valid(char_valid), .char_data(char_data),
    .pop_req(pop_req), .rx_data(rx_data), .lsr_rd(lsr_rd), .ctrl_wr(ctrl_wr),
    .ctrl_wdata(ctrl_wdata), .data_ready(data_ready), .overrun(overrun),
    .trig_irq(trig_irq), .rx_level(rx_level), .tx_ptr_clr(tx_ptr_clr), .fifo_on(fifo_on)
  );

  // {threshold select[1:0], pushes[4:0], expected trig_irq}
  localparam logic [7:0] VEC [8] = '{
    {2'b00, 5'd0, 1'b0}, {2'b00, 5'd1, 1'b1}, {2'b01, 5'd3, 1'b0}, {2'b01, 5'd4, 1'b1},
    {2'b10, 5'd7, 1'b0}, {2'b10, 5'd8, 1'b1}, {2'b11, 5'd13, 1'b0}, {2'b11, 5'd14, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    char_valid = 1'b1; char_data = d;
    @(negedge clk);
    char_valid = 1'b0;
  endtask

  task automatic pop_chk(input string req, input logic [7:0] exp);
    pop_req = 1'b1;
    @(negedge clk);
    pop_req = 1'b0;
    chk(req, rx_data, exp);
  endtask

  task automatic wr_ctrl(input logic [7:0] w);
    ctrl_wr = 1'b1; ctrl_wdata = w;
    @(negedge clk);
    ctrl_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic lsr_read();
    lsr_rd = 1'b1;
    @(negedge clk);
    lsr_rd = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 level", rx_level, 0);
    chk("R1 data_ready", data_ready, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 trig_irq", trig_irq, 0);
    chk("R1 fifo_on", fifo_on, 1);

    // R7 / R6 vector table: clear, select threshold, fill, check
    for (int v = 0; v < 8; v++) begin
      wr_ctrl({2'b00, VEC[v][7:6], 4'b0011});
      for (int i = 0; i < int'(VEC[v][5:1]); i++) push(8'(i));
      chk("R7 trig_irq", trig_irq, int'(VEC[v][0]));
      chk("R6 data_ready", data_ready, int'(VEC[v][5:1] != 0));
      chk("R7 level", rx_level, int'(VEC[v][5:1]));
    end

    // R7 drop below threshold of 4
    wr_ctrl(8'b0001_0011);
    for (int i = 0; i < 4; i++) push(8'h10 + 8'(i));
    chk("R7 at 4", trig_irq, 1);
    pop_chk("R2 first", 8'h10);
    chk("R7 below 4", trig_irq, 0);

    // R10 disabled write: threshold kept, clear ignored
    wr_ctrl(8'b0011_0010);
    chk("R10 fifo_on", fifo_on, 0);
    chk("R10 level kept", rx_level, 3);
    push(8'h13);
    chk("R10 threshold kept", trig_irq, 1);
    wr_ctrl(8'b0000_0011);
    chk("R10 fifo_on back", fifo_on, 1);
    chk("R8 empties", rx_level, 0);
    chk("R6 cleared", data_ready, 0);

    // R2 pop on empty
    pop_req = 1'b1; @(negedge clk); pop_req = 1'b0;
    chk("R2 empty pop level", rx_level, 0);

    // R3 overrun on full
    for (int i = 0; i < 16; i++) push(8'hA0 + 8'(i));
    chk("R3 no ovr yet", overrun, 0);
    push(8'hFF);
    chk("R3 overrun", overrun, 1);
    chk("R3 level", rx_level, 16);
    for (int i = 0; i < 16; i++) pop_chk("R3 contents", 8'hA0 + 8'(i));
    chk("R3 dropped", rx_level, 0);
    chk("R5 sticky", overrun, 1);
    lsr_read();
    chk("R5 clear", overrun, 0);

    // R4 swap at full
    for (int i = 0; i < 16; i++) push(8'h40 + 8'(i));
    char_valid = 1'b1; char_data = 8'h77; pop_req = 1'b1;
    @(negedge clk);
    char_valid = 1'b0; pop_req = 1'b0;
    chk("R4 no overrun", overrun, 0);
    chk("R4 level", rx_level, 16);
    chk("R4 popped", rx_data, 8'h40);
    for (int i = 1; i < 16; i++) pop_chk("R4 order", 8'h40 + 8'(i));
    pop_chk("R4 new byte", 8'h77);

    // R5 overrun and status read together
    for (int i = 0; i < 16; i++) push(8'(i));
    char_valid = 1'b1; char_data = 8'hEE; lsr_rd = 1'b1;
    @(negedge clk);
    char_valid = 1'b0; lsr_rd = 1'b0;
    chk("R5 same cycle", overrun, 1);

    // R8 clear keeps overrun
    wr_ctrl(8'b0000_0011);
    chk("R8 level", rx_level, 0);
    chk("R8 ready", data_ready, 0);
    chk("R8 overrun kept", overrun, 1);
    lsr_read();

    // R9 transmit clear pulse
    push(8'h5A);
    ctrl_wr = 1'b1; ctrl_wdata = 8'b0000_0101;
    @(negedge clk);
    ctrl_wr = 1'b0;
    chk("R9 pulse", tx_ptr_clr, 1);
    @(negedge clk);
    chk("R9 self clear", tx_ptr_clr, 0);
    chk("R9 rx untouched", rx_level, 1);
    pop_chk("R9 rx byte", 8'h5A);

    summary();
  end
endmodule